// File: doc/BRIEF.md
# GPIO Bank Register File with Bitwise Write Aliases

This block holds the control state for one bank of 32 general-purpose pins, arranged as four ports of eight pins. Each port has four registers. The mode register selects GPIO use of a pin, with 1 meaning GPIO. The drive-enable register makes a pin an output when its bit is 1. The data-out register holds the value a pin drives. The read-only sample register holds the synchronized pad level. A simple synchronous bus reaches these registers with a byte address and 32-bit data, and a read returns its data in the cycle after the request.

The three writable registers can each be reached at two addresses. A plain write replaces the whole byte. A masked-alias write carries a per-pin write enable in bits 15:8 and the new values in bits 7:0. With the alias, software can flip a single pin with one write instead of a read-modify-write sequence. The block drives the pad output and output-enable lines and also presents each pin's observed level.

Top module: `gpio_mw_bank`

## Requirements
- R1: After reset, every mode, drive-enable and data-out register reads 0, `pad_oe` is 0 and `pad_out` is 0.
- R2: A plain write loads bits 7:0 of `bus_wdata` into the addressed register at the clock edge that takes the request. Bits 31:8 have no effect.
- R3: A masked-alias write sets register bit i to `bus_wdata[i]` when `bus_wdata[8+i]` is 1 and leaves it unchanged when that enable bit is 0.
- R4: Address map, with the port number p (0..3) adding 4*p: plain mode 0x00, drive-enable 0x10, data-out 0x20, sample 0x30; masked alias of mode 0x80, of drive-enable 0x90, of data-out 0xA0. Only word-aligned addresses are mapped. Pin b of port p is bit 8*p+b of the pin-wide ports.
- R5: The sample register equals `pad_in` delayed through two flops. A change on `pad_in` first shows in the sample register after the second rising edge. Writes to 0x30..0x3C have no effect.
- R6: A read returns its data on `bus_rdata` after the next rising edge, with the register byte in bits 7:0 and zeros above. A read of a masked alias returns the current value of the plain register behind it.
- R7: `pad_oe` bit n is 1 only when both the drive-enable bit n and the mode bit n are 1. A 0 in mode forces the pad output enable low.
- R8: `pad_out` bit n equals data-out bit n.
- R9: `pin_level` bit n equals data-out bit n when drive-enable bit n is 1, and the sample bit n otherwise.
- R10: A write to an unmapped address (low two bits non-zero, offsets 0x40..0x7F, 0xB0..0xFF) changes no register, and a read from one returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Request valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address within the bank |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| pad_in | input | 32 | Raw pad input levels |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |
| pin_level | output | 32 | Observed level per pin |

## Verification
A corrupted mode, drive-enable or data-out bit shows on `pad_oe`, `pad_out` and `pin_level` in the cycle after the write that caused it. The bench compares those three buses after every transaction, so a bad merge in an alias write or a mis-decoded port is caught at once, even before the register is read back. A wrong synchronizer depth shows as a sample level that moves one cycle early or late, and a directed step on `pad_in` tests this. Decode errors that touch the wrong register or the wrong port show up on the pins of the port that should have stayed still.

// File: rtl/gpio_mw_pkg.sv
package gpio_mw_pkg;

  localparam int PIN_W   = 8;
  localparam int PORTS   = 4;
  localparam int PORT_AW = $clog2(PORTS);
  localparam int PINS    = PORTS * PIN_W;
  localparam int ADDR_W  = 8;
  localparam int KIND_W  = 3;

  // register kinds, taken from address bits 6:4
  localparam logic [KIND_W-1:0] K_MODE  = 3'd0;
  localparam logic [KIND_W-1:0] K_DRIVE = 3'd1;
  localparam logic [KIND_W-1:0] K_DOUT  = 3'd2;
  localparam logic [KIND_W-1:0] K_SAMP  = 3'd3;

  typedef struct packed {
    logic               hit;
    logic               masked;
    logic [KIND_W-1:0]  kind;
    logic [PORT_AW-1:0] port;
  } addr_dec_t;

  // address split: bit 7 alias, 6:4 kind, 3:2 port, 1:0 must be zero
  function automatic addr_dec_t decode_addr(input logic [ADDR_W-1:0] a);
    addr_dec_t d;
    d.masked = a[7];
    d.kind   = a[6:4];
    d.port   = a[2 +: PORT_AW];
    d.hit    = (a[1:0] == 2'b00) &&
               (int'(a[3:2]) < PORTS) &&
               (a[7] ? (a[6:4] <= K_DOUT) : (a[6:4] <= K_SAMP));
    return d;
  endfunction

  function automatic logic [PIN_W-1:0] merge_masked(
      input logic [PIN_W-1:0] old_v,
      input logic [PIN_W-1:0] new_v,
      input logic [PIN_W-1:0] en);
    return (old_v & ~en) | (new_v & en);
  endfunction

endpackage

// File: rtl/gpio_mw_decode.sv
module gpio_mw_decode
  import gpio_mw_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_en,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  output logic [PORTS-1:0]     wr_mode,
  output logic [PORTS-1:0]     wr_drive,
  output logic [PORTS-1:0]     wr_dout,
  output logic                 wr_masked,
  output logic                 rd_hit,
  output logic [KIND_W-1:0]    rd_kind,
  output logic [PORT_AW-1:0]   rd_port
);

  addr_dec_t dec;
  logic      wr_go;

  assign dec       = decode_addr(bus_addr);
  assign wr_go     = bus_en && bus_we && dec.hit;
  assign wr_masked = dec.masked;
  assign rd_hit    = bus_en && !bus_we && dec.hit;
  assign rd_kind   = dec.kind;
  assign rd_port   = dec.port;

  generate
    for (genvar p = 0; p < PORTS; p++) begin : g_port_sel
      logic port_match;
      assign port_match  = (dec.port == PORT_AW'(p));
      assign wr_mode[p]  = wr_go && port_match && (dec.kind == K_MODE);
      assign wr_drive[p] = wr_go && port_match && (dec.kind == K_DRIVE);
      assign wr_dout[p]  = wr_go && port_match && (dec.kind == K_DOUT);
    end
  endgenerate

  // R4
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_mode, wr_drive, wr_dout}));

  // R10
  read_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_en && bus_we) |-> ({wr_mode, wr_drive, wr_dout} == '0));

endmodule

// File: rtl/gpio_mw_port_regs.sv
module gpio_mw_port_regs
  import gpio_mw_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_mode,
  input  logic               wr_drive,
  input  logic               wr_dout,
  input  logic               wr_masked,
  input  logic [2*PIN_W-1:0] wdata,
  output logic [PIN_W-1:0]   mode_q,
  output logic [PIN_W-1:0]   drive_q,
  output logic [PIN_W-1:0]   dout_q
);

  logic [PIN_W-1:0] new_v;
  logic [PIN_W-1:0] wr_en_bits;
  logic             any_wr;

  assign new_v      = wdata[PIN_W-1:0];
  assign wr_en_bits = wr_masked ? wdata[2*PIN_W-1:PIN_W] : {PIN_W{1'b1}};
  assign any_wr     = wr_mode || wr_drive || wr_dout;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      drive_q <= '0;
      dout_q  <= '0;
    end else begin
      if (wr_mode)  mode_q  <= merge_masked(mode_q,  new_v, wr_en_bits);
      if (wr_drive) drive_q <= merge_masked(drive_q, new_v, wr_en_bits);
      if (wr_dout)  dout_q  <= merge_masked(dout_q,  new_v, wr_en_bits);
    end
  end

  // R3
  dout_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dout && wr_masked) |=>
      (((dout_q ^ $past(dout_q)) & ~$past(wdata[2*PIN_W-1:PIN_W])) == '0));

  // R3
  drive_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_drive && wr_masked) |=>
      (((drive_q ^ $past(drive_q)) & ~$past(wdata[2*PIN_W-1:PIN_W])) == '0));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_wr |=> $stable({mode_q, drive_q, dout_q}));

endmodule

// File: rtl/gpio_mw_sync.sv
module gpio_mw_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];
  logic         armed_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;

  assign q = stage_q[STAGES-1];

  // R5
  sync_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> (q == $past(stage_q[STAGES-2])));

endmodule

// File: rtl/gpio_mw_bank.sv
module gpio_mw_bank
  import gpio_mw_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [PINS-1:0]   pad_in,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_oe,
  output logic [PINS-1:0]   pin_level
);

  logic [PORTS-1:0]   wr_mode, wr_drive, wr_dout;
  logic               wr_masked;
  logic               rd_hit;
  logic [KIND_W-1:0]  rd_kind;
  logic [PORT_AW-1:0] rd_port;

  logic [PIN_W-1:0]   mode_q  [PORTS];
  logic [PIN_W-1:0]   drive_q [PORTS];
  logic [PIN_W-1:0]   dout_q  [PORTS];
  logic [PINS-1:0]    mode_flat, drive_flat, dout_flat, samp_flat;
  logic [PIN_W-1:0]   rd_byte;
  logic               unused_hi;

  assign unused_hi = ^bus_wdata[DATA_W-1:2*PIN_W];

  gpio_mw_decode u_decode (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .wr_mode   (wr_mode),
    .wr_drive  (wr_drive),
    .wr_dout   (wr_dout),
    .wr_masked (wr_masked),
    .rd_hit    (rd_hit),
    .rd_kind   (rd_kind),
    .rd_port   (rd_port)
  );

  generate
    for (genvar p = 0; p < PORTS; p++) begin : g_port
      gpio_mw_port_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_mode   (wr_mode[p]),
        .wr_drive  (wr_drive[p]),
        .wr_dout   (wr_dout[p]),
        .wr_masked (wr_masked),
        .wdata     (bus_wdata[2*PIN_W-1:0]),
        .mode_q    (mode_q[p]),
        .drive_q   (drive_q[p]),
        .dout_q    (dout_q[p])
      );
      assign mode_flat [p*PIN_W +: PIN_W] = mode_q[p];
      assign drive_flat[p*PIN_W +: PIN_W] = drive_q[p];
      assign dout_flat [p*PIN_W +: PIN_W] = dout_q[p];
    end
  endgenerate

  gpio_mw_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (samp_flat)
  );

  assign pad_out   = dout_flat;
  assign pad_oe    = drive_flat & mode_flat;
  assign pin_level = (drive_flat & dout_flat) | (~drive_flat & samp_flat);

  always_comb begin
    rd_byte = '0;
    if (rd_hit) begin
      case (rd_kind)
        K_MODE:  rd_byte = mode_q[rd_port];
        K_DRIVE: rd_byte = drive_q[rd_port];
        K_DOUT:  rd_byte = dout_q[rd_port];
        K_SAMP:  rd_byte = samp_flat[int'(rd_port)*PIN_W +: PIN_W];
        default: rd_byte = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 bus_rdata <= '0;
    else if (bus_en && !bus_we) bus_rdata <= {{(DATA_W-PIN_W){1'b0}}, rd_byte};
  end

  // R6
  read_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we) |=> (bus_rdata[DATA_W-1:PIN_W] == '0));

  // R10
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && !rd_hit) |=> (bus_rdata == '0));

  // R7
  oe_needs_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_mode[0]) |=> ((pad_oe[PIN_W-1:0] & ~mode_q[0]) == '0));

endmodule

// File: tb/tb_gpio_mw_bank.sv
`timescale 1ns/1ps
module tb_gpio_mw_bank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = 32'hA5C3_0F96;
  logic [31:0] pad_out, pad_oe, pin_level;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [7:0]  m_mode [4];
  logic [7:0]  m_drive[4];
  logic [7:0]  m_dout [4];
  logic [31:0] m_samp;

  always #4 clk = ~clk;

  gpio_mw_bank dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pin_level(pin_level)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pack4(input logic [7:0] a0, input logic [7:0] a1,
                                        input logic [7:0] a2, input logic [7:0] a3);
    return {a3, a2, a1, a0};
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    int off  = int'(a);
    int kind = (off % 128) / 16;
    int port = (off % 16) / 4;
    bit alias_sel = off >= 128;
    if (off % 4 != 0) return 32'h0;
    if (alias_sel && kind > 2) return 32'h0;
    if (!alias_sel && kind > 3) return 32'h0;
    case (kind)
      0: return {24'h0, m_mode[port]};
      1: return {24'h0, m_drive[port]};
      2: return {24'h0, m_dout[port]};
      default: return {24'h0, m_samp[port*8 +: 8]};
    endcase
  endfunction

  task automatic model_write(input logic [7:0] a, input logic [31:0] d);
    int off  = int'(a);
    int kind = (off % 128) / 16;
    int port = (off % 16) / 4;
    bit alias_sel = off >= 128;
    logic [7:0] en = alias_sel ? d[15:8] : 8'hFF;
    if (off % 4 != 0 || kind > 2) return;
    case (kind)
      0: m_mode[port]  = m_mode[port]  ^ ((m_mode[port]  ^ d[7:0]) & en);
      1: m_drive[port] = m_drive[port] ^ ((m_drive[port] ^ d[7:0]) & en);
      default: m_dout[port] = m_dout[port] ^ ((m_dout[port] ^ d[7:0]) & en);
    endcase
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
    model_write(a, d);
  endtask

  task automatic bus_read_check(input logic [7:0] a, input string req);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a; bus_wdata = $urandom;
    @(negedge clk);
    bus_en = 1'b0;
    check(req, bus_rdata, exp_read(a));
  endtask

  task automatic check_pins();
    logic [31:0] mo = pack4(m_mode[0], m_mode[1], m_mode[2], m_mode[3]);
    logic [31:0] dr = pack4(m_drive[0], m_drive[1], m_drive[2], m_drive[3]);
    logic [31:0] dt = pack4(m_dout[0], m_dout[1], m_dout[2], m_dout[3]);
    logic [31:0] lv = '0;
    for (int i = 0; i < 32; i++) lv[i] = dr[i] ? dt[i] : m_samp[i];
    check("R8 pad_out", pad_out, dt);
    check("R7 pad_oe", pad_oe, dr & mo);
    check("R9 pin_level", pin_level, lv);
  endtask

  task automatic settle_pads(input logic [31:0] v);
    @(negedge clk);
    pad_in = v;
    repeat (3) @(negedge clk);
    m_samp = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int p = 0; p < 4; p++) begin
      m_mode[p] = '0; m_drive[p] = '0; m_dout[p] = '0;
    end
    m_samp = pad_in;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 pad_oe", pad_oe, 32'h0);
    check("R1 pad_out", pad_out, 32'h0);
    for (int p = 0; p < 4; p++) begin
      bus_read_check(8'(p * 4), "R1 mode");
      bus_read_check(8'(16 + p * 4), "R1 drive");
      bus_read_check(8'(32 + p * 4), "R1 dout");
    end
    check_pins();

    // R2 plain write ignores upper bits; R6 alias read
    bus_write(8'h24, 32'hFFFF_FF3C);
    bus_read_check(8'h24, "R2 plain write");
    bus_read_check(8'hA4, "R6 alias read");
    check_pins();

    // R3 masked write on single bits
    bus_write(8'hA4, 32'h0000_8101);
    bus_read_check(8'h24, "R3 masked merge");
    bus_write(8'hA4, 32'h0000_00FF);
    bus_read_check(8'h24, "R3 zero enable");

    // R7 drive without mode
    bus_write(8'h14, 32'h0000_00FF);
    check("R7 oe gated", pad_oe, 32'h0);
    bus_write(8'h84, 32'h0000_0F0F);
    check("R7 oe partial", pad_oe[15:8], 8'h0F);
    check_pins();

    // R10 and R5 ignored writes
    bus_write(8'h34, 32'h0000_FFFF);
    bus_write(8'hB0, 32'h0000_FFFF);
    bus_write(8'h26, 32'h0000_FF00);
    bus_write(8'h44, 32'h0000_FFFF);
    bus_read_check(8'h24, "R10 dout unchanged");
    bus_read_check(8'h14, "R10 drive unchanged");
    bus_read_check(8'h34, "R5 sample read");
    bus_read_check(8'hB0, "R10 unmapped read");
    bus_read_check(8'h25, "R10 unaligned read");
    check_pins();

    // R5 two-edge synchronizer latency on port 0 (drive 0)
    bus_write(8'h10, 32'h0000_0000);
    settle_pads(32'h0000_0000);
    @(negedge clk);
    pad_in = 32'h0000_00FF;
    @(negedge clk);
    check("R5 after one edge", pin_level[7:0], 8'h00);
    @(negedge clk);
    check("R5 after two edges", pin_level[7:0], 8'hFF);
    m_samp = pad_in;

    // R4 address map sweep across ports and kinds
    for (int p = 0; p < 4; p++) begin
      bus_write(8'(p * 4), 32'(8'h11 * (p + 1)));
      bus_write(8'(16 + p * 4), 32'(8'h21 + p));
      bus_write(8'(32 + p * 4), 32'(8'h5A ^ p));
    end
    for (int p = 0; p < 4; p++) begin
      bus_read_check(8'(p * 4), "R4 mode map");
      bus_read_check(8'(128 + 16 + p * 4), "R4 drive alias map");
      bus_read_check(8'(160 + p * 4), "R4 dout alias map");
    end
    check_pins();

    // random mix
    for (int it = 0; it < 500; it++) begin
      logic [7:0] a;
      logic [31:0] d;
      int sel = $urandom_range(0, 9);
      a = {1'($urandom), 3'($urandom_range(0, 4)), 2'($urandom),
           ($urandom_range(0, 7) == 0) ? 2'($urandom) : 2'b00};
      d = $urandom;
      if (sel < 5) begin
        bus_write(a, d);
        check_pins();
      end else if (sel < 9) begin
        bus_read_check(a, "R2 R3 R6 random read");
      end else begin
        settle_pads($urandom);
        check_pins();
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule